// File: doc/BRIEF.md
# Software-Toggled Two-Wire Bus Target Decoder

A memory-mapped peripheral through which a host processor drives a two-wire serial bus (I2C) one line transition at a time. The host never writes the clock and data lines directly. It writes a mask to a "raise" offset to pull lines high, or to a "lower" offset to pull them low. The block keeps a model of both line levels. From the change each write makes, it infers clock rising edges and the start and stop conditions.

A protocol engine follows the host through each transfer. Bits move most significant bit first, and only on rising clock edges. After a start condition the engine collects a 7-bit target address and a direction bit. It looks the address up in a parameterised table of attached targets, then acknowledges or ignores the transfer. On a write transfer it hands each received byte to the selected target with a one-cycle valid pulse. On a read transfer it raises a one-cycle byte request, latches the byte the target returns, and presents that byte bit by bit on the data line as seen by the host. The data line the host reads back is the wired-AND of the host's own level and the block's drive, as on an open-drain bus.

Top module: `i2cbb_target_bus`

## Requirements
- R1: After reset the read-back word at the raise offset (0x0) is 3 (SCL = bit 0 = 1, SDA = bit 1 = 1), the target select vector is all zero, and the received-byte valid and byte-request outputs are low.
- R2: A write to offset 0x0 sets each line bit whose write-data bit is 1. A write to offset 0x4 clears each line bit whose write-data bit is 1. All other line bits are unchanged, and write-data bits above bit 1 have no effect. A read at 0x0 returns {SDA, SCL} in bits 1:0 and zero above; a read at any other offset returns zero.
- R3: A write that moves SDA from 1 to 0 while SCL stays 1 is a start condition. It begins address reception with the bit count at zero, from any state and even in the middle of a byte (a repeated start).
- R4: Address and data bits are sampled only on writes that move SCL from 0 to 1. Writes that toggle SDA while SCL is 0 shift nothing.
- R5: On the 8th rising edge after a start, the 7 address bits (bits 7:1 of the byte) are compared against the target table. On a hit, the select output goes one-hot on the matching entry (the lowest index when entries repeat), and SDA reads 0 until the 9th rising edge. On a miss, SDA stays released, the select stays zero and all clocks are ignored until the next start.
- R6: Direction bit 0 (byte bit 0) selects a write transfer. On the 8th rising edge of each data byte the received-byte valid output pulses for one cycle with the byte, and SDA reads 0 (acknowledge) until the 9th rising edge.
- R7: Direction bit 1 selects a read transfer. The byte request pulses for one cycle on the 8th rising edge of the address and of each sent byte. The byte is latched when the target raises its valid input. From the 9th rising edge on, each rising edge presents the next bit on the read-back SDA, most significant bit first. The 8th rising edge of a sent byte releases SDA.
- R8: In a read transfer the host's SDA at the 9th rising edge is its acknowledge. 0 loads and presents the next byte; 1 ends the transfer, clears the select and ignores further clocks.
- R9: A write that moves SDA from 0 to 1 while SCL stays 1 is a stop condition. It returns the block to idle, clears the select and releases SDA.
- R10: The SDA level read back is the AND of the host's SDA bit and the block's drive. While the block acknowledges, SDA reads 0 even though the host holds SDA at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Byte offset of the register access |
| reg_wdata | input | REG_DW | Write mask |
| reg_rdata | output | REG_DW | Read-back line levels (combinational on reg_addr) |
| tgt_sel | output | NUM_TGT | One-hot select of the addressed target |
| rx_valid | output | 1 | One-cycle pulse: a byte was received for the selected target |
| rx_byte | output | 8 | Byte received from the host |
| tx_req | output | 1 | One-cycle pulse: the selected target must supply the next byte |
| tx_valid | input | 1 | Target byte is valid this cycle |
| tx_byte | input | 8 | Byte to send to the host |

## Verification
The bench builds the block with three table entries holding 0x50, 0x1D and 0x50 again. The repeated 0x50 puts the lowest-index priority of the one-hot select within reach, and 0x1D covers a second, distinct match. An address missing from the table, 0x22, drives the miss path. The register offsets keep their defaults at 0x0 and 0x4. A byte-wide target model answers every byte request, so transfers of several bytes run with both acknowledge and non-acknowledge endings.

// File: rtl/i2cbb_pkg.sv
package i2cbb_pkg;
  localparam int BYTE_W  = 8;
  localparam int TADDR_W = 7;
  localparam int CNT_W   = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_TX
  } bus_state_e;

  typedef struct packed {
    logic sda;
    logic scl;
  } lines_t;
endpackage

// File: rtl/i2cbb_line_regs.sv
module i2cbb_line_regs
  import i2cbb_pkg::*;
#(
  parameter int REG_AW  = 4,
  parameter int REG_DW  = 32,
  parameter int SET_OFF = 0,
  parameter int CLR_OFF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              sda_drv,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              sda_host_nxt,
  output logic              rise_evt,
  output logic              start_evt,
  output logic              stop_evt
);
  lines_t cur_q, nxt;
  logic   wr_set, wr_clr, line_en;
  lines_t mask;

  assign wr_set  = reg_wr && (reg_addr == REG_AW'(SET_OFF));
  assign wr_clr  = reg_wr && (reg_addr == REG_AW'(CLR_OFF));
  assign line_en = wr_set || wr_clr;
  assign mask    = lines_t'(reg_wdata[1:0]);

  always_comb begin
    nxt = cur_q;
    if (wr_set)      nxt = cur_q | mask;
    else if (wr_clr) nxt = cur_q & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_q <= '{sda: 1'b1, scl: 1'b1};
    else if (line_en) cur_q <= nxt;
  end

  assign sda_host_nxt = nxt.sda;
  assign rise_evt  = !cur_q.scl && nxt.scl;
  assign start_evt = cur_q.scl && nxt.scl && cur_q.sda && !nxt.sda;
  assign stop_evt  = cur_q.scl && nxt.scl && !cur_q.sda && nxt.sda;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == REG_AW'(SET_OFF))
      reg_rdata = REG_DW'({cur_q.sda & sda_drv, cur_q.scl});
  end

  // R2: a set of bit 0 leaves SCL high on the next cycle
  p_set_scl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && reg_wdata[0]) |=> cur_q.scl);
  // R2: a clear of bit 1 leaves the host SDA low on the next cycle
  p_clr_sda_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && reg_wdata[1]) |=> !cur_q.sda);
endmodule

// File: rtl/i2cbb_addr_match.sv
module i2cbb_addr_match
  import i2cbb_pkg::*;
#(
  parameter int NUM_TGT = 2,
  parameter logic [NUM_TGT*TADDR_W-1:0] TGT_ADDRS = {7'h1D, 7'h50}
) (
  input  logic [TADDR_W-1:0] addr,
  output logic               hit,
  output logic [NUM_TGT-1:0] sel
);
  logic [NUM_TGT-1:0] eq;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_cmp
    assign eq[g] = (addr == TGT_ADDRS[g*TADDR_W +: TADDR_W]);
  end

  // lowest set bit wins
  assign sel = eq & (~eq + NUM_TGT'(1));
  assign hit = |eq;
endmodule

// File: rtl/i2cbb_proto_fsm.sv
module i2cbb_proto_fsm
  import i2cbb_pkg::*;
#(
  parameter int NUM_TGT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_evt,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic               sda_in,
  input  logic               hit,
  input  logic [NUM_TGT-1:0] hit_sel,
  input  logic               tx_valid,
  input  logic [BYTE_W-1:0]  tx_byte,
  output logic [TADDR_W-1:0] match_addr,
  output logic               sda_drv,
  output logic [NUM_TGT-1:0] tgt_sel,
  output logic               rx_valid,
  output logic [BYTE_W-1:0]  rx_byte,
  output logic               tx_req
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  bus_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BYTE_W-1:0]  msg_q, msg_d;
  logic [BYTE_W-1:0]  hold_q;
  logic [BYTE_W-1:0]  rxb_q, rxb_d;
  logic [NUM_TGT-1:0] sel_q, sel_d;
  logic               drv_q, drv_d;
  logic               dir_q, dir_d;
  logic               rxv_q, rxv_d;
  logic               txr_q, txr_d;
  logic               upd_en;

  assign upd_en = rise_evt || start_evt || stop_evt;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    msg_d   = msg_q;
    rxb_d   = rxb_q;
    sel_d   = sel_q;
    drv_d   = drv_q;
    dir_d   = dir_q;
    rxv_d   = 1'b0;
    txr_d   = 1'b0;
    if (start_evt) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      drv_d   = 1'b1;
      sel_d   = '0;
    end else if (stop_evt) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      drv_d   = 1'b1;
      sel_d   = '0;
    end else if (rise_evt) begin
      unique case (state_q)
        ST_ADDR: begin
          if (cnt_q < LAST_BIT) begin
            msg_d = {msg_q[BYTE_W-2:0], sda_in};
            cnt_d = cnt_q + 1'b1;
          end else if (cnt_q == LAST_BIT) begin
            msg_d = {msg_q[BYTE_W-2:0], sda_in};
            if (hit) begin
              sel_d = hit_sel;
              drv_d = 1'b0;
              dir_d = sda_in;
              txr_d = sda_in;
              cnt_d = ACK_SLOT;
            end else begin
              state_d = ST_IDLE;
              cnt_d   = '0;
            end
          end else begin
            cnt_d = '0;
            if (dir_q) begin
              state_d = ST_TX;
              msg_d   = hold_q;
              drv_d   = hold_q[BYTE_W-1];
            end else begin
              state_d = ST_RX;
              drv_d   = 1'b1;
            end
          end
        end
        ST_RX: begin
          if (cnt_q < LAST_BIT) begin
            msg_d = {msg_q[BYTE_W-2:0], sda_in};
            cnt_d = cnt_q + 1'b1;
          end else if (cnt_q == LAST_BIT) begin
            rxb_d = {msg_q[BYTE_W-2:0], sda_in};
            rxv_d = 1'b1;
            drv_d = 1'b0;
            cnt_d = ACK_SLOT;
          end else begin
            drv_d = 1'b1;
            cnt_d = '0;
          end
        end
        ST_TX: begin
          if (cnt_q < LAST_BIT) begin
            msg_d = {msg_q[BYTE_W-2:0], 1'b0};
            drv_d = msg_q[BYTE_W-2];
            cnt_d = cnt_q + 1'b1;
          end else if (cnt_q == LAST_BIT) begin
            drv_d = 1'b1;
            txr_d = 1'b1;
            cnt_d = ACK_SLOT;
          end else if (!sda_in) begin
            msg_d = hold_q;
            drv_d = hold_q[BYTE_W-1];
            cnt_d = '0;
          end else begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            drv_d   = 1'b1;
            sel_d   = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      msg_q   <= '0;
      rxb_q   <= '0;
      sel_q   <= '0;
      drv_q   <= 1'b1;
      dir_q   <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      msg_q   <= msg_d;
      rxb_q   <= rxb_d;
      sel_q   <= sel_d;
      drv_q   <= drv_d;
      dir_q   <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxv_q <= 1'b0;
      txr_q <= 1'b0;
    end else begin
      rxv_q <= rxv_d;
      txr_q <= txr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (tx_valid) hold_q <= tx_byte;
  end

  assign match_addr = msg_q[TADDR_W-1:0];
  assign sda_drv    = drv_q;
  assign tgt_sel    = sel_q;
  assign rx_valid   = rxv_q;
  assign rx_byte    = rxb_q;
  assign tx_req     = txr_q;

  p_start_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state_q == ST_ADDR && cnt_q == '0));
  p_hold_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt || start_evt || stop_evt) |=> $stable(cnt_q));
  p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q));
  p_rx_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |=> !rxv_q);
  p_txreq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    txr_q |=> !txr_q);
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state_q == ST_IDLE && sel_q == '0));
  p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> drv_q);
endmodule

// File: rtl/i2cbb_target_bus.sv
module i2cbb_target_bus
  import i2cbb_pkg::*;
#(
  parameter int REG_AW  = 4,
  parameter int REG_DW  = 32,
  parameter int SET_OFF = 0,
  parameter int CLR_OFF = 4,
  parameter int NUM_TGT = 2,
  parameter logic [NUM_TGT*TADDR_W-1:0] TGT_ADDRS = {7'h1D, 7'h50}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [REG_DW-1:0]  reg_wdata,
  output logic [REG_DW-1:0]  reg_rdata,
  output logic [NUM_TGT-1:0] tgt_sel,
  output logic               rx_valid,
  output logic [7:0]         rx_byte,
  output logic               tx_req,
  input  logic               tx_valid,
  input  logic [7:0]         tx_byte
);
  logic [1:0]         rst_pipe;
  logic               rst_int_n;
  logic               sda_drv, sda_host_nxt, rise_evt, start_evt, stop_evt;
  logic               hit;
  logic [NUM_TGT-1:0] hit_sel;
  logic [TADDR_W-1:0] match_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  i2cbb_line_regs #(
    .REG_AW(REG_AW), .REG_DW(REG_DW), .SET_OFF(SET_OFF), .CLR_OFF(CLR_OFF)
  ) u_lines (
    .clk(clk), .rst_n(rst_int_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sda_drv(sda_drv), .reg_rdata(reg_rdata),
    .sda_host_nxt(sda_host_nxt), .rise_evt(rise_evt),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cbb_addr_match #(.NUM_TGT(NUM_TGT), .TGT_ADDRS(TGT_ADDRS)) u_match (
    .addr(match_addr), .hit(hit), .sel(hit_sel)
  );

  i2cbb_proto_fsm #(.NUM_TGT(NUM_TGT)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .rise_evt(rise_evt), .start_evt(start_evt),
    .stop_evt(stop_evt), .sda_in(sda_host_nxt), .hit(hit), .hit_sel(hit_sel),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .match_addr(match_addr),
    .sda_drv(sda_drv), .tgt_sel(tgt_sel), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_req(tx_req)
  );
endmodule

// File: tb/tb_i2cbb_target_bus.sv
module tb_i2cbb_target_bus;
  logic        clk, rst_n, reg_wr, tx_valid;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, rv;
  logic [2:0]  tgt_sel;
  logic        rx_valid, tx_req;
  logic [7:0]  rx_byte, tx_byte;
  int n_chk = 0, n_bad = 0, rx_cnt = 0, txr_cnt = 0, tx_idx = 0;
  logic [7:0]  tx_q [3];

  i2cbb_target_bus #(.NUM_TGT(3), .TGT_ADDRS({7'h50, 7'h1D, 7'h50})) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tgt_sel(tgt_sel),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
    .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // target model: answers each byte request on the following edge
  always @(negedge clk) begin
    if (tx_req) begin
      tx_valid <= 1'b1;
      tx_byte  <= tx_q[tx_idx % 3];
      tx_idx++;
      txr_cnt++;
    end else begin
      tx_valid <= 1'b0;
    end
    if (rx_valid) rx_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [3:0] a);
    reg_addr = a;
    #1;
    rv = reg_rdata;
  endtask

  task automatic scl_h(); wr(4'h0, 32'h1); endtask
  task automatic scl_l(); wr(4'h4, 32'h1); endtask
  task automatic sda_h(); wr(4'h0, 32'h2); endtask
  task automatic sda_l(); wr(4'h4, 32'h2); endtask
  task automatic set_sda(input logic b); if (b) sda_h(); else sda_l(); endtask

  task automatic do_start(); sda_h(); scl_h(); sda_l(); scl_l(); endtask
  task automatic do_stop();  sda_l(); scl_h(); sda_h(); endtask

  task automatic send7(input logic [7:0] b);
    for (int i = 7; i >= 1; i--) begin
      set_sda(b[i]); scl_h(); scl_l();
    end
  endtask

  // host writes one byte; ack check and optional received-byte check
  task automatic wbyte(input logic [7:0] b, input logic exp_ack, input logic chk_rx, input string req);
    send7(b);
    set_sda(b[0]); scl_h();
    if (chk_rx) begin
      chk({req, " rx_valid"}, 32'(rx_valid), 32'h1);
      chk({req, " rx_byte"}, 32'(rx_byte), 32'(b));
    end
    scl_l(); sda_h();
    rd(4'h0);
    chk({req, " ack level"}, 32'(rv[1]), exp_ack ? 32'h0 : 32'h1);
    scl_h(); scl_l();
  endtask

  // host reads one byte; bit 7 already presented, SCL low, host SDA high
  task automatic rbyte(input logic [7:0] b, input logic last);
    rd(4'h0); chk("R7 bit7", 32'(rv[1]), 32'(b[7]));
    for (int k = 6; k >= 0; k--) begin
      scl_h(); scl_l();
      rd(4'h0); chk("R7 data bit", 32'(rv[1]), 32'(b[k]));
    end
    scl_h();
    chk("R7 tx_req on 8th rise", 32'(tx_req), 32'h1);
    rd(4'h0); chk("R7 released", 32'(rv[1]), 32'h1);
    scl_l();
    if (!last) begin
      sda_l(); scl_h(); scl_l(); sda_h();
    end else begin
      scl_h();
      chk("R8 nack clears select", 32'(tgt_sel), 32'h0);
      scl_l();
    end
  endtask

  task automatic t_reset();
    rd(4'h0);
    chk("R1 lines", rv, 32'h3);
    chk("R1 select", 32'(tgt_sel), 32'h0);
    chk("R1 pulses", {30'h0, rx_valid, tx_req}, 32'h0);
  endtask

  task automatic t_regs();
    wr(4'h4, 32'hFFFF_FFFC); rd(4'h0); chk("R2 upper bits ignored", rv, 32'h3);
    wr(4'h4, 32'h1);         rd(4'h0); chk("R2 clear SCL", rv, 32'h2);
    wr(4'h0, 32'h1);         rd(4'h0); chk("R2 set SCL", rv, 32'h3);
    rd(4'h4);                          chk("R2 other offset reads zero", rv, 32'h0);
    wr(4'h4, 32'h3);         rd(4'h0); chk("R2 clear both", rv, 32'h0);
    wr(4'h0, 32'h3);         rd(4'h0); chk("R2 set both", rv, 32'h3);
    chk("R2 no transfer started", 32'(tgt_sel), 32'h0);
  endtask

  task automatic t_write();
    int rx0;
    do_start();
    send7(8'h3A);
    // R4: SDA toggles with SCL low must not shift
    sda_h(); sda_l(); sda_h();
    set_sda(1'b0); scl_h();
    chk("R5 select entry 1", 32'(tgt_sel), 32'h2);
    rd(4'h0); chk("R5 ack low", 32'(rv[1]), 32'h0);
    scl_l(); sda_h();
    rd(4'h0); chk("R10 ack wins over host high", 32'(rv[1]), 32'h0);
    scl_h();
    rd(4'h0); chk("R6 released after 9th rise", 32'(rv[1]), 32'h1);
    scl_l();
    rx0 = rx_cnt;
    wbyte(8'hA5, 1'b1, 1'b1, "R6 byte0");
    wbyte(8'h3C, 1'b1, 1'b1, "R6 byte1");
    chk("R6 two pulses", 32'(rx_cnt - rx0), 32'h2);
    do_stop();
    chk("R9 select cleared", 32'(tgt_sel), 32'h0);
    rd(4'h0); chk("R9 lines released", rv, 32'h3);
  endtask

  task automatic t_nomatch();
    int rx0;
    do_start();
    wbyte(8'h44, 1'b0, 1'b0, "R5 miss");
    chk("R5 miss select", 32'(tgt_sel), 32'h0);
    rx0 = rx_cnt;
    wbyte(8'hFF, 1'b0, 1'b0, "R5 miss ignored");
    chk("R5 miss no byte", 32'(rx_cnt - rx0), 32'h0);
    do_stop();
  endtask

  task automatic t_read();
    int r0;
    tx_q[0] = 8'hC3; tx_q[1] = 8'h5A; tx_q[2] = 8'h00;
    tx_idx = 0; r0 = txr_cnt;
    do_start();
    send7(8'hA1);
    set_sda(1'b1); scl_h();
    chk("R5 duplicate picks lowest", 32'(tgt_sel), 32'h1);
    chk("R7 tx_req on address", 32'(tx_req), 32'h1);
    scl_l(); sda_h();
    rd(4'h0); chk("R7 address ack", 32'(rv[1]), 32'h0);
    scl_h(); scl_l();
    rbyte(8'hC3, 1'b0);
    rbyte(8'h5A, 1'b1);
    for (int i = 0; i < 3; i++) begin scl_h(); scl_l(); end
    rd(4'h0); chk("R8 clocks ignored after nack", 32'(rv[1]), 32'h1);
    chk("R8 request count", 32'(txr_cnt - r0), 32'h3);
    do_stop();
  endtask

  task automatic t_restart();
    int rx0;
    do_start();
    wbyte(8'h3A, 1'b1, 1'b0, "R3 first address");
    for (int i = 0; i < 4; i++) begin set_sda(1'b1); scl_h(); scl_l(); end
    sda_h(); scl_h(); sda_l(); scl_l();
    rx0 = rx_cnt;
    wbyte(8'h3A, 1'b1, 1'b0, "R3 restart address");
    wbyte(8'h81, 1'b1, 1'b1, "R3 byte after restart");
    chk("R3 one byte after restart", 32'(rx_cnt - rx0), 32'h1);
    do_stop();
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    tx_valid = 1'b0; tx_byte = '0;
    tx_q[0] = '0; tx_q[1] = '0; tx_q[2] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_write();
    t_nomatch();
    t_read();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule